// File: doc/BRIEF.md
# Fiducial-Triggered Event Sequence Generator

This block is the transmitting end of an event-based timing link. Before each machine cycle, a host fills a small sequence RAM. Each entry is an 8-bit event code plus a 20-bit cycle offset. The block emits one 16-bit word on every clock cycle. The upper byte of each word is an event code and the lower byte is a distributed-data byte taken from a side input.

An asynchronous fiducial input passes through a synchronizer. On each rising edge of the fiducial, the block emits a marker code and restarts an offset counter. It then walks the RAM from address 0. An entry is emitted in the slot where the counter equals the entry's offset. Every other slot carries the null code. Playback ends at an end code, after the last RAM address, or when the counter saturates. The block then idles until the next fiducial.

A fiducial that arrives during playback has two effects. It raises a sticky overrun flag, and it restarts the sequence.

Top module: `evt_seq_gen`

## Requirements
- R1: While rst_ni is low, word_o is 0, word_vld_o is 0 and overrun_o is 0. Every RAM entry resets to the end code 0x7F, so a fiducial with nothing loaded yields only the marker word.
- R2: From the first clock edge after reset, word_vld_o is high every cycle. word_o[15:8] carries the event code. word_o[7:0] equals dbus_i as sampled at the previous clock edge.
- R3: Suppose fid_i is first sampled high at clock edge k. Then word_o[15:8] holds the marker code 0x7D between edges k+2 and k+3. A fid_i held high for many cycles yields exactly one marker.
- R4: Entries are taken in ascending address order, and their offsets must ascend strictly and be at least 1. Each entry's code appears exactly `offset` clock cycles after the marker word.
- R5: Code 0x00 is sent in every slot that carries no marker and no scheduled entry, including all idle slots.
- R6: An entry holding 0x7F ends playback without being emitted. Entries after it are not sent until the next fiducial, which restarts from address 0.
- R7: A fiducial rising edge during playback sets overrun_o, which stays set until reset. The same edge restarts playback from address 0, and offsets are then counted from the new marker.
- R8: A fiducial rising edge while playback is idle leaves overrun_o unchanged.
- R9: An entry whose code is 0x00 takes its slot as a null word. The entries after it are still emitted at their own offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock, one word per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe for the sequence RAM |
| wr_addr_i | input | ADDR_W | Host write address |
| wr_code_i | input | 8 | Event code to store |
| wr_ofs_i | input | 20 | Cycle offset from the marker to store |
| fid_i | input | 1 | Asynchronous fiducial, rising edge active |
| dbus_i | input | 8 | Distributed-data byte |
| word_o | output | 16 | Link word: code in [15:8], data in [7:0] |
| word_vld_o | output | 1 | High on every cycle out of reset |
| overrun_o | output | 1 | Sticky flag: fiducial arrived during playback |

## Verification
A wrong address index or offset counter shows at the ports as an event code landing in the wrong slot. It can also show as a code emitted twice, or a code missing after the marker. Such an error is visible within one cycle of the slot where the entry was due. Loss of state on a restart shows as events timed from the old marker, or as a missing overrun flag, as soon as the second sequence plays. A synchronizer fault shows as a marker displaced from its fixed latency, or as repeated markers while the fiducial is held high.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;
  localparam int CODE_W = 8;
  localparam int OFS_W  = 20;
  localparam int DATA_W = 8;
  localparam int WORD_W = CODE_W + DATA_W;

  localparam logic [CODE_W-1:0] CODE_NULL = 8'h00;
  localparam logic [CODE_W-1:0] CODE_MARK = 8'h7D;
  localparam logic [CODE_W-1:0] CODE_END  = 8'h7F;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [OFS_W-1:0]  ofs;
  } seq_entry_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_PLAY = 1'b1} play_st_e;
endpackage

// File: rtl/evt_fid_sync.sv
module evt_fid_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic pulse_o
);
  // chain[STAGES] is the delayed copy used for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain <= '0;
    else         chain <= {chain[STAGES-1:0], async_i};
  end

  assign pulse_o = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/evt_seq_ram.sv
module evt_seq_ram
  import evt_seq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  seq_entry_t        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output seq_entry_t        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  seq_entry_t mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem[g] <= '{code: CODE_END, ofs: '0};
      end else if (wr_en_i && (wr_addr_i == ADDR_W'(g))) begin
        mem[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/evt_seq_player.sv
module evt_seq_player
  import evt_seq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fid_pulse_i,
  input  seq_entry_t        ent_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [CODE_W-1:0] code_o,
  output logic              playing_o,
  output logic              overrun_o
);
  localparam logic [ADDR_W-1:0] LAST_IDX = '1;
  localparam logic [OFS_W-1:0]  CNT_MAX  = '1;

  play_st_e          state_q;
  logic [ADDR_W-1:0] idx_q;
  logic [OFS_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      cnt_q     <= '0;
      code_o    <= CODE_NULL;
      overrun_o <= 1'b0;
    end else if (fid_pulse_i) begin
      if (state_q == ST_PLAY) overrun_o <= 1'b1;
      state_q <= ST_PLAY;
      idx_q   <= '0;
      cnt_q   <= OFS_W'(1);   // marker slot is offset 0
      code_o  <= CODE_MARK;
    end else if (state_q == ST_PLAY) begin
      cnt_q <= cnt_q + 1'b1;
      if (ent_i.code == CODE_END || cnt_q == CNT_MAX) begin
        state_q <= ST_IDLE;
        code_o  <= CODE_NULL;
      end else if (ent_i.ofs == cnt_q) begin
        code_o <= ent_i.code;
        if (idx_q == LAST_IDX) state_q <= ST_IDLE;
        else                   idx_q   <= idx_q + 1'b1;
      end else begin
        code_o <= CODE_NULL;
      end
    end else begin
      code_o <= CODE_NULL;
    end
  end

  assign rd_addr_o = idx_q;
  assign playing_o = (state_q == ST_PLAY);
endmodule

// File: rtl/evt_seq_gen.sv
module evt_seq_gen
  import evt_seq_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic [OFS_W-1:0]  wr_ofs_i,
  input  logic              fid_i,
  input  logic [DATA_W-1:0] dbus_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              overrun_o
);
  logic              fid_pulse;
  logic              playing;
  logic [ADDR_W-1:0] rd_addr;
  seq_entry_t        rd_ent;
  logic [CODE_W-1:0] code;
  logic [DATA_W-1:0] dbus_q;

  evt_fid_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (fid_i),
    .pulse_o (fid_pulse)
  );

  evt_seq_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i ('{code: wr_code_i, ofs: wr_ofs_i}),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_ent)
  );

  evt_seq_player #(.ADDR_W(ADDR_W)) u_player (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fid_pulse_i (fid_pulse),
    .ent_i       (rd_ent),
    .rd_addr_o   (rd_addr),
    .code_o      (code),
    .playing_o   (playing),
    .overrun_o   (overrun_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbus_q     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      dbus_q     <= dbus_i;
      word_vld_o <= 1'b1;
    end
  end

  assign word_o = {code, dbus_q};
endmodule

// File: rtl/evt_seq_chk.sv
module evt_seq_chk
  import evt_seq_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fid_pulse,
  input logic              playing,
  input logic [WORD_W-1:0] word_o,
  input logic              word_vld_o,
  input logic [DATA_W-1:0] dbus_i,
  input logic              overrun_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_vld_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> word_vld_o);

  assert_data_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (word_o[DATA_W-1:0] == $past(dbus_i)));

  assert_marker_follows_fid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fid_pulse |=> (word_o[WORD_W-1:DATA_W] == CODE_MARK));

  assert_single_marker_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_o[WORD_W-1:DATA_W] == CODE_MARK) |=> (word_o[WORD_W-1:DATA_W] != CODE_MARK));

  assert_idle_null_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!playing && !fid_pulse) |=> (word_o[WORD_W-1:DATA_W] == CODE_NULL));

  assert_overrun_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  assert_overrun_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(fid_pulse && playing));
endmodule

bind evt_seq_gen evt_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fid_pulse  (fid_pulse),
  .playing    (playing),
  .word_o     (word_o),
  .word_vld_o (word_vld_o),
  .dbus_i     (dbus_i),
  .overrun_o  (overrun_o)
);

// File: tb/sim_evt_seq_gen.sv
module sim_evt_seq_gen;
  import evt_seq_pkg::*;

  localparam int ADDR_W = 6;
  localparam int NTAB   = 7;
  localparam seq_entry_t TAB [NTAB] = '{
    '{code: 8'h10, ofs: 20'd3},
    '{code: 8'h21, ofs: 20'd4},
    '{code: 8'h00, ofs: 20'd6},
    '{code: 8'h33, ofs: 20'd10},
    '{code: 8'h4C, ofs: 20'd57},
    '{code: 8'h7F, ofs: 20'd0},
    '{code: 8'h55, ofs: 20'd60}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_code = '0;
  logic [19:0]       wr_ofs = '0;
  logic              fid = 1'b0;
  logic [7:0]        dbus = '0;
  logic [15:0]       word;
  logic              vld;
  logic              ovr;

  always #4 clk = ~clk;

  evt_seq_gen #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_code_i(wr_code), .wr_ofs_i(wr_ofs), .fid_i(fid), .dbus_i(dbus),
    .word_o(word), .word_vld_o(vld), .overrun_o(ovr)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int rec_n = 0;
  logic [7:0] rec_code [64];
  int         rec_cyc  [64];
  always @(negedge clk) begin
    if (rst_n && word[15:8] != 8'h00 && rec_n < 64) begin
      rec_code[rec_n] = word[15:8];
      rec_cyc[rec_n]  = cyc;
      rec_n = rec_n + 1;
    end
  end

  int nchk = 0;
  int nfail = 0;
  logic [7:0] exp_code [8];
  int         exp_ofs  [8];
  int         n_exp = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fire_fid(input int hold, output int at);
    @(negedge clk);
    fid = 1'b1;
    at = cyc;
    repeat (hold) @(negedge clk);
    fid = 1'b0;
  endtask

  // marker at rec[base], then the expected events, nothing else
  task automatic check_seq(input int base, input int fid_at);
    int m;
    chk(rec_code[base] == 8'h7D, "R3 marker code", rec_code[base], 8'h7D);
    chk(rec_cyc[base] - fid_at == 3, "R3 marker latency", rec_cyc[base] - fid_at, 3);
    m = rec_cyc[base];
    for (int i = 0; i < n_exp; i++) begin
      chk(rec_code[base+1+i] == exp_code[i], "R4 R9 event code", rec_code[base+1+i], exp_code[i]);
      chk(rec_cyc[base+1+i] - m == exp_ofs[i], "R4 event offset", rec_cyc[base+1+i] - m, exp_ofs[i]);
    end
    chk(rec_n - base == n_exp + 1, "R6 word count after end", rec_n - base, n_exp + 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int base, t1, t2;
    repeat (3) @(negedge clk);
    chk(word == 16'h0, "R1 word in reset", word, 0);
    chk(vld == 1'b0, "R1 valid in reset", vld, 0);
    chk(ovr == 1'b0, "R1 overrun in reset", ovr, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(vld == 1'b1, "R2 valid after reset", vld, 1);
    chk(rec_n == 0, "R5 idle null codes", rec_n, 0);

    // R1: empty RAM gives marker only
    base = rec_n;
    fire_fid(2, t1);
    repeat (30) @(negedge clk);
    chk(rec_n - base == 1, "R1 empty RAM", rec_n - base, 1);
    chk(rec_code[base] == 8'h7D, "R1 empty RAM marker", rec_code[base], 8'h7D);

    // table walk: load RAM and build expected list
    for (int i = 0; i < NTAB; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(i);
      wr_code = TAB[i].code; wr_ofs = TAB[i].ofs;
    end
    @(negedge clk);
    wr_en = 1'b0;
    begin
      bit done = 1'b0;
      for (int i = 0; i < NTAB; i++) begin
        if (TAB[i].code == 8'h7F) done = 1'b1;
        if (!done && TAB[i].code != 8'h00) begin
          exp_code[n_exp] = TAB[i].code;
          exp_ofs[n_exp]  = int'(TAB[i].ofs);
          n_exp++;
        end
      end
    end

    // run 1: fiducial held high 20 cycles (R3 one marker)
    base = rec_n;
    fire_fid(20, t1);
    repeat (100) @(negedge clk);
    check_seq(base, t1);
    chk(ovr == 1'b0, "R8 no overrun after clean run", ovr, 0);

    // R2 data byte
    dbus = 8'hA5;
    @(negedge clk);
    chk(word[7:0] == 8'hA5, "R2 data byte", word[7:0], 8'hA5);
    dbus = 8'h3C;
    @(negedge clk);
    chk(word[7:0] == 8'h3C, "R2 data byte", word[7:0], 8'h3C);

    // run 2 from idle, then restart during playback
    base = rec_n;
    fire_fid(2, t1);
    repeat (6) @(negedge clk);
    chk(ovr == 1'b0, "R8 idle fiducial no overrun", ovr, 0);
    fire_fid(2, t2);
    repeat (100) @(negedge clk);
    chk(ovr == 1'b1, "R7 overrun set", ovr, 1);
    chk(rec_code[base] == 8'h7D, "R7 first marker", rec_code[base], 8'h7D);
    chk(rec_code[base+1] == 8'h10 && rec_cyc[base+1] - rec_cyc[base] == 3,
        "R7 pre-restart event", rec_cyc[base+1] - rec_cyc[base], 3);
    chk(rec_code[base+2] == 8'h21, "R7 pre-restart event", rec_code[base+2], 8'h21);
    check_seq(base + 3, t2);

    // R7 stickiness across an idle fiducial
    fire_fid(2, t1);
    repeat (80) @(negedge clk);
    chk(ovr == 1'b1, "R7 overrun sticky", ovr, 1);

    rst_n = 1'b0;
    @(negedge clk);
    chk(ovr == 1'b0, "R1 overrun cleared by reset", ovr, 0);
    chk(word == 16'h0, "R1 word cleared by reset", word, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule